// File: doc/BRIEF.md
# Multi-Port RAM with Per-Port Read-During-Write Bypass

This block is a small single-clock storage array. It has two write ports and a parameterised number of read ports, which suits register files and scratch tables inside a larger datapath. Each read port is built in one of two forms, chosen by a parameter.

A registered (synchronous) read port samples its address at the clock edge and presents the word one cycle later. A combinational (asynchronous) read port shows the stored word at its address with no delay. The block has no global read-during-write setting. Each registered read port carries a two-bit bypass mask with one bit for each write port. When a write port that the mask selects writes the address being read in the same cycle, the read returns the incoming data. A write from a port that the mask does not select is not forwarded, and the read returns the word held before that edge.

Two writes to the same address in one cycle are resolved by a fixed priority, and write port 1 wins. All ports share one clock, so no bypass ever crosses a clock boundary.

Top module: `mp_ram_seltrans`

## Requirements
- R1: While `rst_n` is low, every stored word is cleared to zero and every registered read output is zero.
- R2: A word written through either write port appears on any read port that addresses it in a later cycle.
- R3: When both write enables are high with equal addresses, the data of write port 1 is stored and the data of write port 0 is discarded.
- R4: A registered read port with mask bits [1:0] = 2'b00 returns the word held before the edge, even when a same-cycle write targets its address.
- R5: A registered read port with mask bit 0 set shows the write-port-0 data when port 0 writes its address in the same cycle. If its mask bit 1 is clear, a same-cycle write from port 1 to that address is not shown.
- R6: A registered read port with mask bit 1 set shows the write-port-1 data when port 1 writes its address in the same cycle. If its mask bit 0 is clear, a same-cycle write from port 0 to that address is not shown.
- R7: A registered read port with mask 2'b11 shows the winning write's data, which is the port-1 data, when both write ports hit its address in one cycle.
- R8: A bypass is taken only when the write enable is high and the write address equals the read address sampled at that edge. Otherwise the read returns the stored word.
- R9: A registered read port whose enable is low keeps its previous output, even when its address is written.
- R10: An asynchronous read port shows the stored word at its current address combinationally. A write is visible on it right after the edge that performs the write. Its enable and mask have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for all ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 2 | Write enable, bit i for write port i |
| wr_addr | input | 2*AW | Write addresses, port i at [i*AW +: AW] |
| wr_data | input | 2*DW | Write data, port i at [i*DW +: DW] |
| rd_en | input | NRD | Read enable for each read port (no effect on asynchronous ports) |
| rd_addr | input | NRD*AW | Read addresses, port k at [k*AW +: AW] |
| rd_data | output | NRD*DW | Read data, port k at [k*DW +: DW] |

## Verification
Writes and reads of the same address can land in the same cycle, and so can two writes to one address. These collisions are where the bypass masks and the write priority matter. The bench provokes them with directed cycles in which every read port watches an address that one or both write ports target. It follows these with a long stretch of random traffic confined to four addresses, so that collisions occur often. A behavioural reference model predicts each read port's output from its mask and from the stored contents before the edge. The model is compared with the design on every clock, and each comparison is tagged with the case it exercised.

// File: rtl/mp_ram_seltrans_pkg.sv
package mp_ram_seltrans_pkg;

    localparam int unsigned NUM_WR = 2;

    // forwarding choice made by a registered read port at each edge
    typedef enum logic [1:0] {
        BYP_NONE = 2'd0,
        BYP_W0   = 2'd1,
        BYP_W1   = 2'd2
    } byp_sel_e;

endpackage

// File: rtl/mp_ram_seltrans_wres.sv
module mp_ram_seltrans_wres
    import mp_ram_seltrans_pkg::*;
#(
    parameter int unsigned AW = 4
) (
    input  logic [NUM_WR-1:0]    wr_en,
    input  logic [NUM_WR*AW-1:0] wr_addr,
    output logic [NUM_WR-1:0]    wr_commit
);

    logic same_addr;

    assign same_addr = (wr_addr[0 +: AW] == wr_addr[AW +: AW]);

    // port 1 wins a collision: port 0 is dropped when both target one word
    always_comb begin
        wr_commit[1] = wr_en[1];
        wr_commit[0] = wr_en[0] && !(wr_en[1] && same_addr);
    end

endmodule

// File: rtl/mp_ram_seltrans_store.sv
module mp_ram_seltrans_store
    import mp_ram_seltrans_pkg::*;
#(
    parameter int unsigned AW  = 4,
    parameter int unsigned DW  = 8,
    parameter int unsigned NRD = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WR-1:0]    wr_commit,
    input  logic [NUM_WR*AW-1:0] wr_addr,
    input  logic [NUM_WR*DW-1:0] wr_data,
    input  logic [NRD*AW-1:0]    rd_addr,
    output logic [NRD*DW-1:0]    rd_word
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else begin
            for (int p = 0; p < NUM_WR; p++) begin
                if (wr_commit[p]) begin
                    cells[wr_addr[p*AW +: AW]] <= wr_data[p*DW +: DW];
                end
            end
        end
    end

    for (genvar k = 0; k < NRD; k++) begin : g_look
        assign rd_word[k*DW +: DW] = cells[rd_addr[k*AW +: AW]];
    end

endmodule

// File: rtl/mp_ram_seltrans_rdport.sv
module mp_ram_seltrans_rdport
    import mp_ram_seltrans_pkg::*;
#(
    parameter int unsigned  AW    = 4,
    parameter int unsigned  DW    = 8,
    parameter logic [1:0]   TMASK = 2'b00
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 re,
    input  logic [AW-1:0]        ra,
    input  logic [DW-1:0]        stored,
    input  logic [NUM_WR-1:0]    wr_en,
    input  logic [NUM_WR*AW-1:0] wr_addr,
    input  logic [NUM_WR*DW-1:0] wr_data,
    output logic [DW-1:0]        q
);

    byp_sel_e      sel;
    logic [DW-1:0] q_next;
    logic          hit0;
    logic          hit1;

    assign hit0 = TMASK[0] && wr_en[0] && (wr_addr[0 +: AW] == ra);
    assign hit1 = TMASK[1] && wr_en[1] && (wr_addr[AW +: AW] == ra);

    // port 1 data is the stored winner, so it is preferred when both hit
    always_comb begin
        if (hit1) begin
            sel = BYP_W1;
        end else if (hit0) begin
            sel = BYP_W0;
        end else begin
            sel = BYP_NONE;
        end
    end

    always_comb begin
        unique case (sel)
            BYP_W1:   q_next = wr_data[DW +: DW];
            BYP_W0:   q_next = wr_data[0 +: DW];
            BYP_NONE: q_next = stored;
            default:  q_next = stored;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (re) begin
            q <= q_next;
        end
    end

endmodule

// File: rtl/mp_ram_seltrans.sv
module mp_ram_seltrans
    import mp_ram_seltrans_pkg::*;
#(
    parameter int unsigned      AW       = 4,
    parameter int unsigned      DW       = 8,
    parameter int unsigned      NRD      = 5,
    parameter logic [NRD-1:0]   RD_ASYNC = 5'b10000,
    parameter logic [2*NRD-1:0] RD_TMASK = 10'b00_11_10_01_00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        wr_en,
    input  logic [2*AW-1:0]   wr_addr,
    input  logic [2*DW-1:0]   wr_data,
    input  logic [NRD-1:0]    rd_en,
    input  logic [NRD*AW-1:0] rd_addr,
    output logic [NRD*DW-1:0] rd_data
);

    logic [NUM_WR-1:0] wr_commit;
    logic [NRD*DW-1:0] stored_word;
    logic              unused_async_en;

    // enables of combinational ports are deliberately ignored
    assign unused_async_en = ^(rd_en & RD_ASYNC);

    mp_ram_seltrans_wres #(
        .AW (AW)
    ) u_wres (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_commit (wr_commit)
    );

    mp_ram_seltrans_store #(
        .AW  (AW),
        .DW  (DW),
        .NRD (NRD)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_commit (wr_commit),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_word   (stored_word)
    );

    for (genvar k = 0; k < NRD; k++) begin : g_rd
        if (RD_ASYNC[k]) begin : g_comb
            assign rd_data[k*DW +: DW] = stored_word[k*DW +: DW];
        end else begin : g_reg
            mp_ram_seltrans_rdport #(
                .AW    (AW),
                .DW    (DW),
                .TMASK (RD_TMASK[2*k +: 2])
            ) u_port (
                .clk     (clk),
                .rst_n   (rst_n),
                .re      (rd_en[k]),
                .ra      (rd_addr[k*AW +: AW]),
                .stored  (stored_word[k*DW +: DW]),
                .wr_en   (wr_en),
                .wr_addr (wr_addr),
                .wr_data (wr_data),
                .q       (rd_data[k*DW +: DW])
            );
        end
    end

endmodule

// File: rtl/mp_ram_seltrans_chk.sv
module mp_ram_seltrans_chk #(
    parameter int unsigned      AW       = 4,
    parameter int unsigned      DW       = 8,
    parameter int unsigned      NRD      = 5,
    parameter logic [NRD-1:0]   RD_ASYNC = 5'b10000,
    parameter logic [2*NRD-1:0] RD_TMASK = 10'b00_11_10_01_00
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        wr_en,
    input logic [2*AW-1:0]   wr_addr,
    input logic [2*DW-1:0]   wr_data,
    input logic [NRD-1:0]    rd_en,
    input logic [NRD*AW-1:0] rd_addr,
    input logic [NRD*DW-1:0] rd_data
);

    for (genvar k = 0; k < NRD; k++) begin : g_chk
        if (!RD_ASYNC[k]) begin : g_reg
            // R9: a disabled registered port keeps its output
            a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_en[k] |=> $stable(rd_data[k*DW +: DW]));

            if (RD_TMASK[2*k+1]) begin : g_m1
                // R6 / R7: a watched port-1 write is forwarded
                a_r6_w1_forward: assert property (@(posedge clk) disable iff (!rst_n)
                    (rd_en[k] && wr_en[1] && wr_addr[AW +: AW] == rd_addr[k*AW +: AW])
                    |=> rd_data[k*DW +: DW] == $past(wr_data[DW +: DW]));
            end

            if (RD_TMASK[2*k] && !RD_TMASK[2*k+1]) begin : g_m0
                // R5: a watched port-0 write is forwarded
                a_r5_w0_forward: assert property (@(posedge clk) disable iff (!rst_n)
                    (rd_en[k] && wr_en[0] && wr_addr[0 +: AW] == rd_addr[k*AW +: AW])
                    |=> rd_data[k*DW +: DW] == $past(wr_data[0 +: DW]));
            end
        end else begin : g_comb
            // R3: after a port-1 write its data is stored, whatever port 0 did
            a_r3_w1_wins: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en[1] |=> (rd_addr[k*AW +: AW] != $past(wr_addr[AW +: AW]))
                             || (rd_data[k*DW +: DW] == $past(wr_data[DW +: DW])));

            // R10: a lone port-0 write is visible right after the edge
            a_r10_async_w0: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en[0] && !(wr_en[1] && wr_addr[AW +: AW] == wr_addr[0 +: AW]))
                |=> (rd_addr[k*AW +: AW] != $past(wr_addr[0 +: AW]))
                    || (rd_data[k*DW +: DW] == $past(wr_data[0 +: DW])));
        end
    end

endmodule

bind mp_ram_seltrans mp_ram_seltrans_chk #(
    .AW       (AW),
    .DW       (DW),
    .NRD      (NRD),
    .RD_ASYNC (RD_ASYNC),
    .RD_TMASK (RD_TMASK)
) u_chk (.*);

// File: tb/mp_ram_seltrans_tb.sv
`timescale 1ns/1ps
module mp_ram_seltrans_tb;

    localparam int AW  = 4;
    localparam int DW  = 8;
    localparam int NRD = 5;
    localparam int DEPTH = 1 << AW;
    localparam logic [NRD-1:0]   ASYNC = 5'b10000;
    localparam logic [2*NRD-1:0] TMASK = 10'b00_11_10_01_00;

    logic              clk;
    logic              rst_n;
    logic [1:0]        wr_en;
    logic [2*AW-1:0]   wr_addr;
    logic [2*DW-1:0]   wr_data;
    logic [NRD-1:0]    rd_en;
    logic [NRD*AW-1:0] rd_addr;
    logic [NRD*DW-1:0] rd_data;

    mp_ram_seltrans #(
        .AW (AW), .DW (DW), .NRD (NRD), .RD_ASYNC (ASYNC), .RD_TMASK (TMASK)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0] mdl_mem [DEPTH];
    logic [DW-1:0] exp_q   [NRD];
    string         exp_tag [NRD];
    logic [AW-1:0] coll_addr;
    bit            coll_valid;

    initial begin
        for (int i = 0; i < DEPTH; i++) mdl_mem[i] = '0;
        for (int k = 0; k < NRD; k++) begin
            exp_q[k] = '0;
            exp_tag[k] = "R1";
        end
        coll_valid = 1'b0;
        coll_addr  = '0;
    end

    // behavioural reference, evaluated at each rising edge
    always @(posedge clk) begin
        logic [AW-1:0] a0, a1, ra;
        logic          h0, h1;
        a0 = wr_addr[0 +: AW];
        a1 = wr_addr[AW +: AW];
        for (int k = 0; k < NRD; k++) begin
            if (!ASYNC[k]) begin
                ra = rd_addr[k*AW +: AW];
                h0 = wr_en[0] && a0 == ra;
                h1 = wr_en[1] && a1 == ra;
                if (!rst_n) begin
                    exp_q[k] = '0;
                    exp_tag[k] = "R1";
                end else if (!rd_en[k]) begin
                    exp_tag[k] = "R9";
                end else if (TMASK[2*k+1] && h1) begin
                    exp_q[k] = wr_data[DW +: DW];
                    exp_tag[k] = (TMASK[2*k +: 2] == 2'b11) ? "R7" : "R6";
                end else if (TMASK[2*k] && h0) begin
                    exp_q[k] = wr_data[0 +: DW];
                    exp_tag[k] = (TMASK[2*k +: 2] == 2'b11) ? "R7" : "R5";
                end else begin
                    exp_q[k] = mdl_mem[ra];
                    if (h0 || h1)            exp_tag[k] = "R4";
                    else if (wr_en != 2'b00) exp_tag[k] = "R8";
                    else                     exp_tag[k] = "R2";
                end
            end
        end
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mdl_mem[i] = '0;
            coll_valid = 1'b0;
        end else begin
            if (wr_en[0]) mdl_mem[a0] = wr_data[0 +: DW];
            if (wr_en[1]) mdl_mem[a1] = wr_data[DW +: DW];
            coll_valid = (wr_en == 2'b11) && (a0 == a1);
            coll_addr  = a0;
        end
    end

    task automatic check(input string tag, input int k, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s port %0d actual %h expected %h", tag, k, act, exp);
        end
    endtask

    // compare registered ports, apply new inputs, then compare combinational ports
    task automatic step(input logic [1:0] we, input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                        input logic [AW-1:0] a1, input logic [DW-1:0] d1,
                        input logic [NRD-1:0] re, input logic [NRD*AW-1:0] ra);
        logic [AW-1:0] ak;
        @(negedge clk);
        for (int k = 0; k < NRD; k++)
            if (!ASYNC[k]) check(exp_tag[k], k, rd_data[k*DW +: DW], exp_q[k]);
        wr_en   = we;
        wr_addr = {a1, a0};
        wr_data = {d1, d0};
        rd_en   = re;
        rd_addr = ra;
        #1;
        for (int k = 0; k < NRD; k++) begin
            if (ASYNC[k]) begin
                ak = rd_addr[k*AW +: AW];
                check((coll_valid && coll_addr == ak) ? "R3" : "R10", k,
                      rd_data[k*DW +: DW], mdl_mem[ak]);
            end
        end
    endtask

    function automatic logic [NRD*AW-1:0] all_at(input logic [AW-1:0] a);
        logic [NRD*AW-1:0] v;
        for (int k = 0; k < NRD; k++) v[k*AW +: AW] = a;
        return v;
    endfunction

    initial begin : watchdog
        #(8ns * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [NRD*AW-1:0] rv;
        rst_n = 1'b0;
        wr_en = '0; wr_addr = '0; wr_data = '0; rd_en = '0; rd_addr = '0;
        for (int i = 0; i < 3; i++) step(2'b11, 4'd1, 8'h55, 4'd2, 8'h66, '1, all_at(4'd1)); // R1
        rst_n = 1'b1;
        step(2'b00, 4'd0, 8'h00, 4'd0, 8'h00, '1, all_at(4'd1));
        // R4 R5 R7: port 0 writes the watched address, port 1 elsewhere
        step(2'b11, 4'd3, 8'h11, 4'd4, 8'h22, '1, all_at(4'd3));
        // R3 R6 R7: both ports write the watched address
        step(2'b11, 4'd5, 8'hA0, 4'd5, 8'hB1, '1, all_at(4'd5));
        // R2 R3: plain read of the collided word
        step(2'b00, 4'd0, 8'h00, 4'd0, 8'h00, '1, all_at(4'd5));
        // R9: disabled ports while their address is written
        step(2'b10, 4'd0, 8'h00, 4'd5, 8'hCC, '0, all_at(4'd5));
        // R8: writes that miss the read address
        step(2'b11, 4'd7, 8'h77, 4'd8, 8'h88, '1, all_at(4'd3));
        step(2'b00, 4'd0, 8'h00, 4'd0, 8'h00, '1, all_at(4'd5));
        // random traffic over a narrow address range for frequent collisions
        for (int n = 0; n < 4000; n++) begin
            for (int k = 0; k < NRD; k++) rv[k*AW +: AW] = AW'($urandom_range(0, 3));
            step(2'($urandom), AW'($urandom_range(0, 3)), DW'($urandom),
                 AW'($urandom_range(0, 3)), DW'($urandom),
                 NRD'($urandom) | NRD'($urandom), rv);
        end
        step(2'b00, 4'd0, 8'h00, 4'd0, 8'h00, '1, all_at(4'd0));
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule